// File: doc/BRIEF.md
# Double-Buffered Display Window Configuration Bank

This block holds the per-window layer settings of a display pipeline in two copies. Software writes a staging copy through a plain word-addressed write/read port. The scan-out logic only ever sees a separate live copy. A live copy is refreshed from its staging copy only at a frame-sync pulse. This avoids a frame that shows half of an update, such as a new width paired with an old base address.

Two global controls govern the refresh. An arm bit must be set before any refresh happens, and it drops by itself once the frame-sync pulse it armed has been acted on. Each window also has a hold bit. While a window's hold bit is set, that window keeps its live settings at the frame-sync pulse and the other windows refresh normally. Software therefore sets hold bits, edits several fields, clears the hold bits and sets the arm bit. The whole change then lands together at the next frame boundary.

Each window exposes an enable, a format code, a buffer base address, an on-screen origin and a transparency key value. The lowest window has no key storage.

Top module: `win_cfg_bank`

## Requirements
- R1: After reset every live output is zero, every staging register reads as zero, all hold bits are zero and the arm bit is zero.
- R2: A write changes only the staging copy. Reading the same address returns the written value on the cycle after the read strobe, and the live outputs stay as they were.
- R3: Address = {global select, window index, field}, with the field in bits [1:0], the window in bits [3:2] and the global select in bit 4. The window fields are 0 control (bit 0 enable, bits [7:4] format), 1 base address, 2 origin (x in bits [11:0], y in bits [27:16]) and 3 key (bits [23:0]). The global fields are 0 hold mask (bit n is window n) and 1 arm (bit 0).
- R4: A frame-sync pulse with the arm bit clear changes no live output.
- R5: A frame-sync pulse with the arm bit set clears the arm bit. Reading the arm register shows whether a refresh is still pending. A write to the arm register loads bit 0.
- R6: At an armed frame-sync pulse, every window whose hold bit is clear copies its staging copy to its live copy, and every held window keeps its live values.
- R7: Staging values of a held window stay pending and are applied at the first armed frame-sync pulse after its hold bit is cleared.
- R8: Clearing a window's enable bit turns off its live enable only at the armed frame-sync pulse, not at the write.
- R9: Window 0 has no key: writes to its key field are ignored, it reads back as zero, and its live key output stays zero.
- R10: A write in the same cycle as an armed frame-sync pulse goes into the staging copy. The live copy takes the previous staging value, and the new value is applied at the next armed pulse. Writing 1 to the arm register in that same cycle leaves the arm bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync | input | 1 | One-cycle frame-sync pulse |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write word address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 5 | Read word address |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| act_en | output | 4 | Live enable, one bit per window |
| act_fmt | output | 16 | Live format codes, 4 bits per window |
| act_base | output | 128 | Live base addresses, 32 bits per window |
| act_x | output | 48 | Live origin x, 12 bits per window |
| act_y | output | 48 | Live origin y, 12 bits per window |
| act_key | output | 96 | Live key values, 24 bits per window |

## Verification
The assertions assume that frame-sync is a single-cycle pulse, that a live value can move only in a cycle that follows a frame-sync pulse, and that a held window never moves. They also assume that read and write addresses are in range. The stimulus raises vsync for exactly one cycle at a time. It drives every input on the falling clock edge and only uses addresses of existing windows and of the two global registers. Writes coinciding with a pulse are issued on purpose, to exercise the carry-over rule.

// File: rtl/win_bank_pkg.sv
package win_bank_pkg;
    localparam int FLD_W = 2;

    localparam logic [FLD_W-1:0] FLD_CTRL = 2'd0;
    localparam logic [FLD_W-1:0] FLD_BASE = 2'd1;
    localparam logic [FLD_W-1:0] FLD_POS  = 2'd2;
    localparam logic [FLD_W-1:0] FLD_KEY  = 2'd3;

    localparam logic [FLD_W-1:0] GLB_HOLD = 2'd0;
    localparam logic [FLD_W-1:0] GLB_ARM  = 2'd1;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_FMT_LSB = 4;
    localparam int POS_Y_LSB    = 16;
endpackage

// File: rtl/win_slot.sv
module win_slot
    import win_bank_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 32,
    parameter int POS_W   = 12,
    parameter int FMT_W   = 4,
    parameter int KEY_W   = 24,
    parameter bit HAS_KEY = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [FLD_W-1:0]  wr_fld,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              xfer,
    input  logic [FLD_W-1:0]  rd_fld,
    output logic [DATA_W-1:0] rd_word,
    output logic              act_en,
    output logic [FMT_W-1:0]  act_fmt,
    output logic [ADDR_W-1:0] act_base,
    output logic [POS_W-1:0]  act_x,
    output logic [POS_W-1:0]  act_y,
    output logic [KEY_W-1:0]  act_key
);
    typedef struct packed {
        logic              en;
        logic [FMT_W-1:0]  fmt;
        logic [ADDR_W-1:0] base;
        logic [POS_W-1:0]  x;
        logic [POS_W-1:0]  y;
        logic [KEY_W-1:0]  key;
    } cfg_t;

    typedef struct packed {
        cfg_t wrk;
        cfg_t act;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (xfer) begin
            st_d.act = st_q.wrk;
        end
        if (wr_en) begin
            case (wr_fld)
                FLD_CTRL: begin
                    st_d.wrk.en  = wr_data[CTRL_EN_BIT];
                    st_d.wrk.fmt = wr_data[CTRL_FMT_LSB +: FMT_W];
                end
                FLD_BASE: st_d.wrk.base = wr_data[ADDR_W-1:0];
                FLD_POS: begin
                    st_d.wrk.x = wr_data[POS_W-1:0];
                    st_d.wrk.y = wr_data[POS_Y_LSB +: POS_W];
                end
                default: begin
                    if (HAS_KEY) begin
                        st_d.wrk.key = wr_data[KEY_W-1:0];
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_word = '0;
        case (rd_fld)
            FLD_CTRL: begin
                rd_word[CTRL_EN_BIT]               = st_q.wrk.en;
                rd_word[CTRL_FMT_LSB +: FMT_W]     = st_q.wrk.fmt;
            end
            FLD_BASE: rd_word[ADDR_W-1:0] = st_q.wrk.base;
            FLD_POS: begin
                rd_word[POS_W-1:0]         = st_q.wrk.x;
                rd_word[POS_Y_LSB +: POS_W] = st_q.wrk.y;
            end
            default: rd_word[KEY_W-1:0] = st_q.wrk.key;
        endcase
    end

    assign act_en   = st_q.act.en;
    assign act_fmt  = st_q.act.fmt;
    assign act_base = st_q.act.base;
    assign act_x    = st_q.act.x;
    assign act_y    = st_q.act.y;
    assign act_key  = st_q.act.key;

    // R4: without a refresh strobe the live copy never moves
    p_live_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(st_q.act));

    // R6: a refresh copies the staging values seen in the strobe cycle
    p_live_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> (st_q.act == $past(st_q.wrk)));

    // R10: a write coinciding with a refresh survives in the staging copy
    p_wr_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && wr_en && wr_fld == FLD_BASE) |=>
        (st_q.wrk.base == $past(wr_data[ADDR_W-1:0])));
endmodule

// File: rtl/bank_ctrl.sv
module bank_ctrl
    import win_bank_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vsync,
    input  logic               glb_wr,
    input  logic [FLD_W-1:0]   glb_fld,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [NUM_WIN-1:0] hold_q,
    output logic               arm_q,
    output logic [NUM_WIN-1:0] xfer
);
    typedef struct packed {
        logic [NUM_WIN-1:0] hold;
        logic               arm;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  fire;

    assign fire = vsync && c_q.arm;

    always_comb begin
        c_d = c_q;
        if (fire) begin
            c_d.arm = 1'b0;
        end
        if (glb_wr) begin
            case (glb_fld)
                GLB_HOLD: c_d.hold = wr_data[NUM_WIN-1:0];
                GLB_ARM:  c_d.arm  = wr_data[0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    genvar w;
    generate
        for (w = 0; w < NUM_WIN; w++) begin : g_xfer
            assign xfer[w] = fire && !c_q.hold[w];
        end
    endgenerate

    assign hold_q = c_q.hold;
    assign arm_q  = c_q.arm;

    // R5: an acted-on arm drops unless rewritten in the same cycle
    p_arm_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync && arm_q && !(glb_wr && glb_fld == GLB_ARM)) |=> !arm_q);

    // R5: the arm bit only rises through a write
    p_arm_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_q && !(glb_wr && glb_fld == GLB_ARM)) |=> !arm_q);
endmodule

// File: rtl/rd_port.sv
module rd_port
    import win_bank_pkg::*;
#(
    parameter int NUM_WIN  = 4,
    parameter int DATA_W   = 32,
    parameter int WIN_BITS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en,
    input  logic                      rd_glb,
    input  logic [WIN_BITS-1:0]       rd_win,
    input  logic [FLD_W-1:0]          rd_fld,
    input  logic [NUM_WIN*DATA_W-1:0] win_words,
    input  logic [NUM_WIN-1:0]        hold,
    input  logic                      arm,
    output logic [DATA_W-1:0]         rd_data
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rd_t;

    rd_t r_d, r_q;
    logic [DATA_W-1:0] sel_word;

    always_comb begin
        sel_word = '0;
        if (rd_glb) begin
            if (rd_fld == GLB_HOLD) begin
                sel_word[NUM_WIN-1:0] = hold;
            end else if (rd_fld == GLB_ARM) begin
                sel_word[0] = arm;
            end
        end else begin
            for (int w = 0; w < NUM_WIN; w++) begin
                if (rd_win == WIN_BITS'(w)) begin
                    sel_word = win_words[w*DATA_W +: DATA_W];
                end
            end
        end
    end

    always_comb begin
        r_d = r_q;
        if (rd_en) begin
            r_d.data = sel_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_data = r_q.data;

    // R2: read data only changes after a read strobe
    p_rd_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/win_cfg_bank.sv
module win_cfg_bank
    import win_bank_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 32,
    parameter int POS_W   = 12,
    parameter int FMT_W   = 4,
    parameter int KEY_W   = 24,
    localparam int WIN_BITS = $clog2(NUM_WIN),
    localparam int REG_AW   = 1 + WIN_BITS + FLD_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vsync,
    input  logic                     wr_en,
    input  logic [REG_AW-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     rd_en,
    input  logic [REG_AW-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    output logic [NUM_WIN-1:0]       act_en,
    output logic [NUM_WIN*FMT_W-1:0] act_fmt,
    output logic [NUM_WIN*ADDR_W-1:0] act_base,
    output logic [NUM_WIN*POS_W-1:0] act_x,
    output logic [NUM_WIN*POS_W-1:0] act_y,
    output logic [NUM_WIN*KEY_W-1:0] act_key
);
    logic                      wr_glb;
    logic [WIN_BITS-1:0]       wr_win;
    logic [FLD_W-1:0]          wr_fld;
    logic                      rd_glb;
    logic [WIN_BITS-1:0]       rd_win;
    logic [FLD_W-1:0]          rd_fld;
    logic [NUM_WIN-1:0]        hold;
    logic                      arm;
    logic [NUM_WIN-1:0]        xfer;
    logic [NUM_WIN*DATA_W-1:0] win_words;

    assign wr_glb = wr_addr[REG_AW-1];
    assign wr_win = wr_addr[FLD_W +: WIN_BITS];
    assign wr_fld = wr_addr[FLD_W-1:0];
    assign rd_glb = rd_addr[REG_AW-1];
    assign rd_win = rd_addr[FLD_W +: WIN_BITS];
    assign rd_fld = rd_addr[FLD_W-1:0];

    bank_ctrl #(
        .NUM_WIN (NUM_WIN),
        .DATA_W  (DATA_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .vsync   (vsync),
        .glb_wr  (wr_en && wr_glb),
        .glb_fld (wr_fld),
        .wr_data (wr_data),
        .hold_q  (hold),
        .arm_q   (arm),
        .xfer    (xfer)
    );

    genvar w;
    generate
        for (w = 0; w < NUM_WIN; w++) begin : g_win
            win_slot #(
                .DATA_W  (DATA_W),
                .ADDR_W  (ADDR_W),
                .POS_W   (POS_W),
                .FMT_W   (FMT_W),
                .KEY_W   (KEY_W),
                .HAS_KEY (w != 0)
            ) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (wr_en && !wr_glb && wr_win == WIN_BITS'(w)),
                .wr_fld   (wr_fld),
                .wr_data  (wr_data),
                .xfer     (xfer[w]),
                .rd_fld   (rd_fld),
                .rd_word  (win_words[w*DATA_W +: DATA_W]),
                .act_en   (act_en[w]),
                .act_fmt  (act_fmt[w*FMT_W +: FMT_W]),
                .act_base (act_base[w*ADDR_W +: ADDR_W]),
                .act_x    (act_x[w*POS_W +: POS_W]),
                .act_y    (act_y[w*POS_W +: POS_W]),
                .act_key  (act_key[w*KEY_W +: KEY_W])
            );

            // R6: a held window keeps its live settings across a pulse
            p_held_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
                hold[w] |=> ($stable(act_en[w]) && $stable(act_base[w*ADDR_W +: ADDR_W])));
        end
    endgenerate

    rd_port #(
        .NUM_WIN  (NUM_WIN),
        .DATA_W   (DATA_W),
        .WIN_BITS (WIN_BITS)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_glb    (rd_glb),
        .rd_win    (rd_win),
        .rd_fld    (rd_fld),
        .win_words (win_words),
        .hold      (hold),
        .arm       (arm),
        .rd_data   (rd_data)
    );

    // R2: live outputs only move in the cycle after a frame-sync pulse
    p_no_sync_still_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync |=> ($stable(act_en) && $stable(act_fmt) && $stable(act_base)
                    && $stable(act_x) && $stable(act_y) && $stable(act_key)));

    // R9: window 0 never shows a key
    p_no_key0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_key[KEY_W-1:0] == '0));
endmodule

// File: tb/win_cfg_bank_test.sv
module win_cfg_bank_test;
    localparam int PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         vsync = 1'b0;
    logic         wr_en = 1'b0;
    logic [4:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic         rd_en = 1'b0;
    logic [4:0]   rd_addr = '0;
    logic [31:0]  rd_data;
    logic [3:0]   act_en;
    logic [15:0]  act_fmt;
    logic [127:0] act_base;
    logic [47:0]  act_x;
    logic [47:0]  act_y;
    logic [95:0]  act_key;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    win_cfg_bank uut (
        .clk(clk), .rst_n(rst_n), .vsync(vsync),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .act_en(act_en), .act_fmt(act_fmt), .act_base(act_base),
        .act_x(act_x), .act_y(act_y), .act_key(act_key)
    );

    function automatic logic [4:0] wa(input int w, input int f);
        return {1'b0, 2'(w), 2'(f)};
    endfunction
    localparam logic [4:0] A_HOLD = 5'b10000;
    localparam logic [4:0] A_ARM  = 5'b10001;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic pulse();
        @(negedge clk);
        vsync = 1'b1;
        @(negedge clk);
        vsync = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 act_en", 32'(act_en), 0);
        chk("R1 act_base", act_base[63:32], 0);
        chk("R1 act_key", act_key[47:24], 0);
        rd(wa(2, 1), d); chk("R1 staging base", d, 0);
        rd(A_ARM, d);    chk("R1 arm", d, 0);
        rd(A_HOLD, d);   chk("R1 hold", d, 0);
    endtask

    task automatic t_stage();
        logic [31:0] d;
        wr(wa(1, 0), 32'h0000_0031);
        wr(wa(1, 1), 32'h1000_0040);
        wr(wa(1, 2), 32'h0020_0010);
        wr(wa(1, 3), 32'h00AB_CDEF);
        rd(wa(1, 0), d); chk("R2 R3 ctrl readback", d, 32'h31);
        rd(wa(1, 2), d); chk("R2 R3 origin readback", d, 32'h0020_0010);
        chk("R2 live base unchanged", act_base[63:32], 0);
        chk("R2 live en unchanged", 32'(act_en), 0);
    endtask

    task automatic t_unarmed();
        pulse();
        chk("R4 no arm no refresh", act_base[63:32], 0);
    endtask

    task automatic t_armed();
        logic [31:0] d;
        wr(A_ARM, 1);
        rd(A_ARM, d); chk("R5 arm pending", d, 1);
        pulse();
        chk("R6 en", 32'(act_en[1]), 1);
        chk("R3 fmt", 32'(act_fmt[7:4]), 3);
        chk("R6 base", act_base[63:32], 32'h1000_0040);
        chk("R3 x", 32'(act_x[23:12]), 32'h10);
        chk("R3 y", 32'(act_y[23:12]), 32'h20);
        chk("R6 key", 32'(act_key[47:24]), 32'hABCDEF);
        rd(A_ARM, d); chk("R5 arm self clear", d, 0);
    endtask

    task automatic t_hold();
        wr(A_HOLD, 32'h4);
        wr(wa(1, 1), 32'h2222_0000);
        wr(wa(2, 1), 32'h3333_0000);
        wr(A_ARM, 1);
        pulse();
        chk("R6 free window refreshed", act_base[63:32], 32'h2222_0000);
        chk("R6 held window kept", act_base[95:64], 0);
        wr(A_HOLD, 0);
        chk("R7 no refresh before pulse", act_base[95:64], 0);
        wr(A_ARM, 1);
        pulse();
        chk("R7 pending applied", act_base[95:64], 32'h3333_0000);
    endtask

    task automatic t_disable();
        wr(wa(1, 0), 32'h30);
        chk("R8 still enabled after write", 32'(act_en[1]), 1);
        wr(A_ARM, 1);
        chk("R8 still enabled when armed", 32'(act_en[1]), 1);
        pulse();
        chk("R8 disabled at pulse", 32'(act_en[1]), 0);
    endtask

    task automatic t_key0();
        logic [31:0] d;
        wr(wa(0, 3), 32'h0012_3456);
        rd(wa(0, 3), d); chk("R9 key0 reads zero", d, 0);
        wr(A_ARM, 1);
        pulse();
        chk("R9 live key0 zero", 32'(act_key[23:0]), 0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        wr(wa(3, 1), 32'hAAAA_0000);
        wr(A_ARM, 1);
        @(negedge clk);
        vsync = 1'b1; wr_en = 1'b1; wr_addr = wa(3, 1); wr_data = 32'hBBBB_0000;
        @(negedge clk);
        vsync = 1'b0; wr_en = 1'b0;
        chk("R10 live takes old value", act_base[127:96], 32'hAAAA_0000);
        rd(wa(3, 1), d); chk("R10 staging keeps new", d, 32'hBBBB_0000);
        wr(A_ARM, 1);
        pulse();
        chk("R10 carried over", act_base[127:96], 32'hBBBB_0000);
        @(negedge clk);
        vsync = 1'b1; wr_en = 1'b1; wr_addr = A_ARM; wr_data = 1;
        @(negedge clk);
        vsync = 1'b0; wr_en = 1'b0;
        rd(A_ARM, d); chk("R10 R5 arm rewritten at pulse", d, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stage();
        t_unarmed();
        t_armed();
        t_hold();
        t_disable();
        t_key0();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule